// File: doc/BRIEF.md
# Audio Sample Queue with Register and Interrupt Front-End

This block sits between a system bus and the serial side of an audio transmitter. Software fills a deep queue of 32-bit samples by writing to an address window. Any offset inside the window reaches the same queue. A serializer, which is not part of this block, drains the queue through a valid/ready stream port.

A small register file sits beside the window. It holds two sticky event flags with their enable masks, and a control word with a global enable and a self-clearing flush command. A status word reports the fill level. Four read-only words each report one byte of a fixed configuration: sampling rate, data format and sample width.

One level-sensitive interrupt line combines the enabled events under the global enable. The ready event is live: it is high while the queue has room for a refill, that is, while the level is at or below a threshold parameter. The error event is sticky: it latches on a write to a full queue and on a read from an empty one.

The bus is a simple one-cycle request port. `bus_sel` together with `bus_wr` starts an access. Read data appears on `bus_rdata` after the clock edge that accepts the read, and holds until the next read.

The stream port follows valid/ready rules. `aud_data` carries the oldest sample while `aud_valid` is high. The sample leaves on a cycle with both `aud_valid` and `aud_ready` high. While `aud_ready` is low the sample stays in place. `aud_valid` is withdrawn, with no handshake, only in a cycle in which the bus reads the window, because the bus takes the oldest sample in that cycle.

Top module: `audio_fifo_csr`

## Requirements
- R1: The queue keeps up to DEPTH samples in arrival order. A bus read of the window removes the oldest sample and returns it on `bus_rdata` after the accepting edge.
- R2: A bus write to the window while the queue holds DEPTH samples leaves the queue unchanged and sets the error flag, bit 1 of the pending word at offset 0x04.
- R3: A bus read of the window while the queue is empty returns 0 and sets the error flag.
- R4: Every address with bit 8 set selects the queue window, whatever its bits 7:0 hold.
- R5: In the pending word (0x04), writing 1 to bit 1 clears the error flag and writing 0 leaves it. Bit 0 is the ready flag: it reads 1 exactly while the level is at or below THRESH, and writes to it have no effect. Offset 0x00 returns the same two bits.
- R6: The mask word at 0x08 holds the ready enable in bit 0 and the error enable in bit 1, and both read back. Both are 0 after reset.
- R7: `irq` equals ((ready enable AND ready flag) OR (error enable AND error flag)) AND the global enable, evaluated on the state after each clock edge.
- R8: In the control word at 0x0C, bit 0 is the global enable and reads back, resetting to 0. Writing 1 to bit 1 empties the queue; writing 0 to bit 1 does nothing. Bit 1 always reads 0.
- R9: The level word at 0x10 returns the sample count in bits 9:0, a full flag in bit 10 and an empty flag in bit 11. After reset it reads 0x800.
- R10: Offsets 0x20, 0x24 and 0x28 return sampling-rate bits 23:16, 15:8 and 7:0 in bits 7:0. Offset 0x2C returns the format code in bits 1:0 (1 = standard) and the sample width in bits 7:2. Unmapped offsets read 0.
- R11: `aud_valid` is high when the queue is not empty and the bus is not reading the window. `aud_data` shows the oldest sample. A handshake removes that sample, and `aud_data` stays stable while `aud_valid` is high and `aud_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address; top bit selects the queue window |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid after the accepting edge |
| aud_valid | output | 1 | Stream sample available |
| aud_ready | input | 1 | Stream sink accepts the sample |
| aud_data | output | DW | Oldest queued sample |
| irq | output | 1 | Level interrupt |

## Verification
Faults in the queue pointers or level counter show up within one cycle, at either of two places. `aud_data` presents the wrong sample whenever `aud_valid` is high. The level word and the ready flag on `irq` drift from the model on the next edge after a push or a pop.

A lost or unwanted error flag shows on `irq` in the cycle after the offending window access, provided the error enable and the global enable are set. A bad flush or a bad clear-by-one decode appears on the next read of the level word or the pending word. The reference model compares the stream outputs and `irq` on every cycle, so a divergence is reported on the cycle it first becomes visible.

// File: rtl/afe_pkg.sv
package afe_pkg;

  // Register offsets within the non-window half of the address space.
  localparam logic [7:0] OFF_EVSTAT = 8'h00;
  localparam logic [7:0] OFF_PEND   = 8'h04;
  localparam logic [7:0] OFF_MASK   = 8'h08;
  localparam logic [7:0] OFF_CTRL   = 8'h0C;
  localparam logic [7:0] OFF_LEVEL  = 8'h10;
  localparam logic [7:0] OFF_CFG0   = 8'h20;
  localparam logic [7:0] OFF_CFG1   = 8'h24;
  localparam logic [7:0] OFF_CFG2   = 8'h28;
  localparam logic [7:0] OFF_CFG3   = 8'h2C;

  // Bit positions of the two events in the pending and mask words.
  localparam int EV_READY = 0;
  localparam int EV_ERROR = 1;

  // Bit positions in the control word.
  localparam int CTL_ENABLE = 0;
  localparam int CTL_FLUSH  = 1;

  // Serial framing codes reported by the configuration word.
  typedef enum logic [1:0] {
    FMT_STANDARD = 2'd1,
    FMT_LEFT     = 2'd2
  } fmt_e;

  // Level word: count in [9:0], full in bit 10, empty in bit 11.
  function automatic logic [31:0] pack_level(input logic [9:0] cnt,
                                             input logic full,
                                             input logic empty);
    return {20'd0, empty, full, cnt};
  endfunction

endpackage

// File: rtl/afe_fifo.sv
module afe_fifo #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  parameter int CNTW  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [DW-1:0]   push_data,
  input  logic            pop,
  input  logic            flush,
  output logic [DW-1:0]   head,
  output logic [CNTW-1:0] level,
  output logic            full,
  output logic            empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  assign full    = (level == CNTW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      unique case ({do_push, do_pop})
        2'b10:   level <= level + CNTW'(1);
        2'b01:   level <= level - CNTW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/afe_events.sv
module afe_events #(
  parameter int CNTW   = 10,
  parameter int THRESH = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CNTW-1:0] level,
  input  logic            err_set,
  input  logic            err_clr,
  input  logic            mask_we,
  input  logic [1:0]      mask_wdata,
  input  logic            enable,
  output logic            ready_pend,
  output logic            err_pend,
  output logic            ready_en,
  output logic            err_en,
  output logic            irq
);

  // Ready tracks room for a refill and is never stored.
  assign ready_pend = (level <= CNTW'(THRESH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pend <= 1'b0;
      ready_en <= 1'b0;
      err_en   <= 1'b0;
    end else begin
      // A new fault outranks a clear arriving in the same cycle.
      if (err_set)      err_pend <= 1'b1;
      else if (err_clr) err_pend <= 1'b0;
      if (mask_we) begin
        ready_en <= mask_wdata[0];
        err_en   <= mask_wdata[1];
      end
    end
  end

  assign irq = enable & ((ready_en & ready_pend) | (err_en & err_pend));

endmodule

// File: rtl/afe_csr.sv
module afe_csr
  import afe_pkg::*;
#(
  parameter int          DW     = 32,
  parameter int          AW     = 9,
  parameter int          CNTW   = 10,
  parameter logic [23:0] RATE   = 24'd48000,
  parameter logic [5:0]  SWIDTH = 6'd24,
  parameter logic [1:0]  FMT    = 2'd1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [DW-1:0]   fifo_head,
  input  logic [CNTW-1:0] fifo_level,
  input  logic            fifo_full,
  input  logic            fifo_empty,
  input  logic            ev_ready,
  input  logic            ev_error,
  input  logic            ev_ready_en,
  input  logic            ev_error_en,
  output logic            fifo_push,
  output logic            fifo_pop,
  output logic            fifo_flush,
  output logic            err_set,
  output logic            err_clr,
  output logic            mask_we,
  output logic            enable
);

  localparam int WIN_BIT = AW - 1;

  logic        win, regsel, reg_wr;
  logic [7:0]  off;
  logic [31:0] reg_rd;
  logic [9:0]  lvl10;
  logic        unused_bits;

  assign win    = bus_sel &  bus_addr[WIN_BIT];
  assign regsel = bus_sel & ~bus_addr[WIN_BIT];
  assign reg_wr = regsel & bus_wr;
  assign off    = bus_addr[7:0];
  assign lvl10  = 10'(fifo_level);

  assign fifo_push  = win &  bus_wr & ~fifo_full;
  assign fifo_pop   = win & ~bus_wr & ~fifo_empty;
  assign err_set    = win & ((bus_wr & fifo_full) | (~bus_wr & fifo_empty));
  assign fifo_flush = reg_wr & (off == OFF_CTRL) & bus_wdata[CTL_FLUSH];
  assign err_clr    = reg_wr & (off == OFF_PEND) & bus_wdata[EV_ERROR];
  assign mask_we    = reg_wr & (off == OFF_MASK);

  assign unused_bits = ^{bus_addr, bus_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        enable <= 1'b0;
    else if (reg_wr && off == OFF_CTRL) enable <= bus_wdata[CTL_ENABLE];
  end

  always_comb begin
    reg_rd = '0;
    unique case (off)
      OFF_EVSTAT, OFF_PEND: begin
        reg_rd[EV_READY] = ev_ready;
        reg_rd[EV_ERROR] = ev_error;
      end
      OFF_MASK: begin
        reg_rd[EV_READY] = ev_ready_en;
        reg_rd[EV_ERROR] = ev_error_en;
      end
      OFF_CTRL:  reg_rd[CTL_ENABLE] = enable;
      OFF_LEVEL: reg_rd = pack_level(lvl10, fifo_full, fifo_empty);
      OFF_CFG0:  reg_rd[7:0] = RATE[23:16];
      OFF_CFG1:  reg_rd[7:0] = RATE[15:8];
      OFF_CFG2:  reg_rd[7:0] = RATE[7:0];
      OFF_CFG3:  reg_rd[7:0] = {SWIDTH, FMT};
      default:   reg_rd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      if (win) bus_rdata <= fifo_empty ? '0 : fifo_head;
      else     bus_rdata <= DW'(reg_rd);
    end
  end

endmodule

// File: rtl/audio_fifo_csr.sv
module audio_fifo_csr
  import afe_pkg::*;
#(
  parameter int          DEPTH  = 512,
  parameter int          DW     = 32,
  parameter int          AW     = 9,
  parameter int          THRESH = 256,
  parameter logic [23:0] RATE   = 24'd48000,
  parameter logic [5:0]  SWIDTH = 6'd24,
  parameter logic [1:0]  FMT    = FMT_STANDARD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          aud_valid,
  input  logic          aud_ready,
  output logic [DW-1:0] aud_data,
  output logic          irq
);

  localparam int CNTW = $clog2(DEPTH + 1);

  generate
    if (THRESH > DEPTH || CNTW > 10 || AW < 9 || DW < 32) begin : g_bad_params
      $error("audio_fifo_csr: parameter set out of range");
    end
  endgenerate

  logic [DW-1:0]   fifo_head;
  logic [CNTW-1:0] fifo_level;
  logic            fifo_full, fifo_empty;
  logic            bus_push, bus_pop, fifo_flush, strm_pop;
  logic            err_set, err_clr, mask_we;
  logic            ctl_enable, ready_pend, err_pend, ready_en, err_en;
  logic            win_read;

  // The bus takes the oldest sample in a window-read cycle, so the stream yields.
  assign win_read  = bus_sel & ~bus_wr & bus_addr[AW-1];
  assign aud_valid = ~fifo_empty & ~win_read;
  assign aud_data  = fifo_head;
  assign strm_pop  = aud_valid & aud_ready;

  afe_fifo #(.DEPTH(DEPTH), .DW(DW), .CNTW(CNTW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (bus_push),
    .push_data (bus_wdata),
    .pop       (bus_pop | strm_pop),
    .flush     (fifo_flush),
    .head      (fifo_head),
    .level     (fifo_level),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  afe_csr #(
    .DW(DW), .AW(AW), .CNTW(CNTW), .RATE(RATE), .SWIDTH(SWIDTH), .FMT(FMT)
  ) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .fifo_head   (fifo_head),
    .fifo_level  (fifo_level),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty),
    .ev_ready    (ready_pend),
    .ev_error    (err_pend),
    .ev_ready_en (ready_en),
    .ev_error_en (err_en),
    .fifo_push   (bus_push),
    .fifo_pop    (bus_pop),
    .fifo_flush  (fifo_flush),
    .err_set     (err_set),
    .err_clr     (err_clr),
    .mask_we     (mask_we),
    .enable      (ctl_enable)
  );

  afe_events #(.CNTW(CNTW), .THRESH(THRESH)) u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (fifo_level),
    .err_set    (err_set),
    .err_clr    (err_clr),
    .mask_we    (mask_we),
    .mask_wdata (bus_wdata[1:0]),
    .enable     (ctl_enable),
    .ready_pend (ready_pend),
    .err_pend   (err_pend),
    .ready_en   (ready_en),
    .err_en     (err_en),
    .irq        (irq)
  );

endmodule

// File: rtl/afe_checker.sv
module afe_checker #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  parameter int AW    = 9,
  parameter int CNTW  = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic            aud_valid,
  input logic            aud_ready,
  input logic [DW-1:0]   aud_data,
  input logic            irq,
  input logic            enable,
  input logic            err_pend,
  input logic [CNTW-1:0] level,
  input logic            full,
  input logic            empty
);

  logic win_wr, win_rd, flush_cmd;
  assign win_wr    = bus_sel &  bus_wr & bus_addr[AW-1];
  assign win_rd    = bus_sel & ~bus_wr & bus_addr[AW-1];
  assign flush_cmd = bus_sel & bus_wr & ~bus_addr[AW-1] & (bus_addr[7:0] == 8'h0C) & bus_wdata[1];

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNTW'(DEPTH));

  assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && full) |=> err_pend);

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && empty) |=> (bus_rdata == '0 && err_pend));

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !irq);

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_cmd |=> empty);

  assert_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (aud_valid && !aud_ready && !bus_sel) |=> $stable(aud_data));

endmodule

bind audio_fifo_csr afe_checker #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .CNTW(CNTW)) u_afe_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .aud_valid (aud_valid),
  .aud_ready (aud_ready),
  .aud_data  (aud_data),
  .irq       (irq),
  .enable    (ctl_enable),
  .err_pend  (err_pend),
  .level     (fifo_level),
  .full      (fifo_full),
  .empty     (fifo_empty)
);

// File: tb/test_audio_fifo_csr.sv
module test_audio_fifo_csr;

  localparam int          DEPTH = 8;
  localparam int          TH    = 3;
  localparam logic [23:0] RATE  = 24'h0BB80C;
  localparam logic [5:0]  SW    = 6'd24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, aud_ready = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, aud_data;
  logic        aud_valid, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Behavioural reference state.
  int unsigned q[$];
  bit m_err = 0, m_ren = 0, m_een = 0, m_en = 0;
  logic [31:0] m_rd = '0;

  always #10 clk = ~clk;

  audio_fifo_csr #(.DEPTH(DEPTH), .THRESH(TH), .RATE(RATE), .SWIDTH(SW)) i_audio_fifo_csr (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .aud_valid(aud_valid),
    .aud_ready(aud_ready), .aud_data(aud_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit m_ready();
    return q.size() <= TH;
  endfunction

  function automatic bit m_irq();
    return m_en && ((m_ren && m_ready()) || (m_een && m_err));
  endfunction

  function automatic logic [31:0] m_reg(input logic [7:0] off);
    case (off)
      8'h00, 8'h04: return {30'd0, m_err, m_ready()};
      8'h08:        return {30'd0, m_een, m_ren};
      8'h0C:        return {31'd0, m_en};
      8'h10:        return {20'd0, q.size() == 0, q.size() == DEPTH, 10'(q.size())};
      8'h20:        return {24'd0, RATE[23:16]};
      8'h24:        return {24'd0, RATE[15:8]};
      8'h28:        return {24'd0, RATE[7:0]};
      8'h2C:        return {24'd0, SW, 2'b01};
      default:      return '0;
    endcase
  endfunction

  // One bus/stream cycle: drive, check combinational outputs, advance model, check after edge.
  task automatic cyc(input bit s, input bit w, input logic [8:0] a, input logic [31:0] d,
                     input bit r, input string tag);
    bit ev, fpre;
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; aud_ready = r;
    #1;
    ev = (q.size() > 0) && !(s && !w && a[8]);
    check("R11 aud_valid", {31'd0, aud_valid}, {31'd0, ev});
    if (ev) check("R11 aud_data", aud_data, q[0]);
    fpre = (q.size() >= DEPTH);
    if (s && !w && !a[8]) m_rd = m_reg(a[7:0]);
    if (ev && r) void'(q.pop_front());
    if (s && a[8]) begin
      if (w) begin
        if (!fpre) q.push_back(d); else m_err = 1;
      end else if (q.size() > 0) m_rd = q.pop_front();
      else begin m_rd = '0; m_err = 1; end
    end else if (s && w) begin
      case (a[7:0])
        8'h04: if (d[1]) m_err = 0;
        8'h08: begin m_ren = d[0]; m_een = d[1]; end
        8'h0C: begin m_en = d[0]; if (d[1]) q.delete(); end
        default: ;
      endcase
    end
    @(posedge clk);
    #2;
    check("R7 irq", {31'd0, irq}, {31'd0, m_irq()});
    if (s && !w) check(tag, bus_rdata, m_rd);
  endtask

  task automatic rd(input logic [8:0] a, input string tag);
    cyc(1, 0, a, '0, 0, tag);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input string tag);
    cyc(1, 1, a, d, 0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R7 reset irq", {31'd0, irq}, 32'd0);
    check("R11 reset aud_valid", {31'd0, aud_valid}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    rd(9'h010, "R9 reset level word 0x800");
    rd(9'h008, "R6 reset mask");
    rd(9'h020, "R10 rate high byte");
    rd(9'h024, "R10 rate mid byte");
    rd(9'h028, "R10 rate low byte");
    rd(9'h02C, "R10 format and width");
    rd(9'h034, "R10 unmapped offset");

    wr(9'h008, 32'h3, "R6 mask write");
    rd(9'h008, "R6 mask readback");
    rd(9'h00C, "R8 enable still off");
    wr(9'h00C, 32'h1, "R8 enable on");
    rd(9'h00C, "R8 enable readback, flush bit reads 0");
    rd(9'h004, "R5 ready live while empty");
    wr(9'h004, 32'h1, "R5 write to ready bit");
    rd(9'h004, "R5 ready unaffected by write");
    rd(9'h000, "R5 status alias");

    wr(9'h100, 32'hA000_0001, "R4 window base");
    wr(9'h137, 32'hA000_0002, "R4 odd offset");
    wr(9'h1FC, 32'hA000_0003, "R4 top offset");
    wr(9'h1AA, 32'hA000_0004, "R4 mid offset");
    rd(9'h010, "R9 level four");
    rd(9'h004, "R5 ready low above threshold");

    cyc(0, 0, '0, '0, 0, "R11 stall");
    cyc(0, 0, '0, '0, 1, "R11 pop");
    cyc(0, 0, '0, '0, 0, "R11 stall again");
    cyc(1, 0, 9'h155, '0, 1, "R1 window read takes oldest");
    cyc(0, 0, '0, '0, 1, "R11 pop after bus read");

    for (int i = 0; i < DEPTH + 2; i++) wr(9'h100 + 9'(i), 32'hB000_0000 + i, "R2 fill");
    rd(9'h010, "R9 full flag");
    rd(9'h004, "R2 error flag after overflow");
    wr(9'h004, 32'h0, "R5 write zero");
    rd(9'h004, "R5 error held after zero write");
    wr(9'h004, 32'h2, "R5 clear error");
    rd(9'h004, "R5 error cleared");

    for (int i = 0; i < DEPTH; i++) rd(9'h1F0, "R1 drain in order");
    rd(9'h100, "R3 empty read returns zero");
    rd(9'h004, "R3 error flag after underflow");
    wr(9'h004, 32'h2, "R5 clear error");

    wr(9'h100, 32'hC1, "R1 push");
    wr(9'h101, 32'hC2, "R1 push");
    wr(9'h00C, 32'h1, "R8 flush bit zero");
    rd(9'h010, "R8 no flush on zero");
    wr(9'h00C, 32'h3, "R8 flush");
    rd(9'h010, "R8 level after flush");
    rd(9'h00C, "R8 flush bit reads zero");

    wr(9'h100, 32'hD1, "R11 push");
    cyc(1, 1, 9'h104, 32'hD2, 1, "R11 push with stream pop");
    cyc(1, 1, 9'h108, 32'hD3, 1, "R11 push with stream pop");
    cyc(0, 0, '0, '0, 1, "R11 pop");
    cyc(0, 0, '0, '0, 1, "R11 pop empty");

    wr(9'h00C, 32'h0, "R7 global disable");
    rd(9'h00C, "R8 disabled readback");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule